// File: doc/BRIEF.md
# Two-Channel Serial Audio Transmitter

This block takes left/right PCM sample pairs from an internal decoder and shifts them out on a three-wire serial audio link: bit clock, word select and one data line. It also drives an oversampled master clock for an external converter. All clocks come from one fast input clock by division. The master clock runs at half the input clock rate. The bit clock is 64 times the sample rate, and there are 256 or 384 master clock periods per frame.

Each frame holds 64 bit-clock slots, 32 per channel. Word select is low for the left channel and data goes MSB first. Two framings are available. In the standard framing the MSB follows the word-select edge by one slot. In the right-justified framing the LSB sits in the last slot before word select changes. Sample width, framing and clock ratio are captured only at a frame boundary. A new sample pair is taken by a valid/ready handshake once per frame. If no pair is offered, the frame carries zeros and an underrun flag is raised. Three enable inputs model tri-state pads for the data line, the word-select line and the two clocks.

The controller is a three-state machine. ST_IDLE is held during reset and lasts one cycle after it. ST_IDLE goes to ST_LEFT on the next cycle and loads the first frame. ST_LEFT goes to ST_RIGHT at the end of slot 31. ST_RIGHT goes back to ST_LEFT at the end of slot 63; this is the frame boundary, where the configuration and a new sample pair are loaded.

Top module: `sao_serial_tx`

## Requirements
- R1: While reset is held, `mclk_o`, `bclk_o`, `ws_o`, `sd_o` and `underrun` are low and `smp_ready` is high. The first clock after reset release loads a frame.
- R2: `mclk_o` toggles on every clock. The bit clock has a period of 8 clocks (low 4, high 4) when `cfg_mclk384`=0 and 12 clocks (low 6, high 6) when it is 1. A frame is 64 bit-clock periods.
- R3: `ws_o` is low for slots 0 to 31 (left channel) and high for slots 32 to 63 (right channel).
- R4: With `cfg_rjust`=0, the MSB of each channel is in slot 1 of its half and the following bits go out MSB first in the next slots.
- R5: With `cfg_rjust`=1, each channel's bits end with the LSB in slot 31 of its half, MSB first.
- R6: Width code `cfg_width` 0/1/2/3 selects 16/18/20/22 bits. Samples are left-aligned with the MSB at bit 21, and only the top width bits are sent. Every other slot drives data low.
- R7: `smp_ready` is high for exactly one clock at each frame boundary (last clock of slot 63) and in the first cycle after reset. A pair is taken when `smp_valid` and `smp_ready` are both high.
- R8: If `smp_valid` is low at a frame boundary, the next frame sends zeros on both channels and `underrun` is high for that whole frame.
- R9: Changes to `cfg_width`, `cfg_rjust` and `cfg_mclk384` take effect only from the next frame boundary.
- R10: With `en_data`, `en_ws` or `en_clk` low, the matching pads (`sd_o`; `ws_o`; `bclk_o` and `mclk_o`) and the output-enable flag are low in the same cycle. Internal timing continues unchanged.
- R11: `sd_o` and `ws_o` change only in the cycle where `bclk_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock (twice the master clock rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Sample width code |
| cfg_rjust | input | 1 | 1 selects right-justified framing |
| cfg_mclk384 | input | 1 | 1 selects 384x master ratio, 0 selects 256x |
| en_data | input | 1 | Enable for the data pad |
| en_ws | input | 1 | Enable for the word-select pad |
| en_clk | input | 1 | Enable for both clock pads |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Sample pair taken at this edge if valid |
| smp_left | input | 22 | Left sample, MSB at bit 21 |
| smp_right | input | 22 | Right sample, MSB at bit 21 |
| mclk_o | output | 1 | Master clock pad |
| bclk_o | output | 1 | Bit clock pad |
| ws_o | output | 1 | Word-select pad |
| sd_o | output | 1 | Serial data pad |
| oe_data | output | 1 | Data pad driven |
| oe_ws | output | 1 | Word-select pad driven |
| oe_clk | output | 1 | Clock pads driven |
| underrun | output | 1 | Current frame carries zeros for lack of a sample |

## Verification
A corrupted slot or divider count shows at the ports within one bit-clock period. It appears as a bit-clock edge in the wrong cycle, or as a data bit that lands one slot early or late. A state machine stuck in one channel holds word select still past slot 31. A latched configuration that tracks its inputs too early misplaces the data bits or changes the bit-clock period in the middle of a frame. The comparison on every clock catches all of these within the same frame.

// File: rtl/sao_pkg.sv
package sao_pkg;

    localparam int SAMPLE_W    = 22;
    localparam int CH_SLOTS    = 32;
    localparam int FRAME_SLOTS = 2 * CH_SLOTS;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS);
    localparam int IDX_W       = $clog2(SAMPLE_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEFT,
        ST_RIGHT
    } frame_state_e;

    typedef struct packed {
        logic [1:0] wcode;
        logic       rjust;
        logic       mclk384;
    } fmt_cfg_t;

    function automatic int word_bits(input logic [1:0] code);
        return 16 + 2 * int'(code);
    endfunction

endpackage

// File: rtl/sao_clkdiv.sv
module sao_clkdiv #(
    parameter int HALF_LO = 4,
    parameter int HALF_HI = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic hi_sel,
    output logic mclk_q,
    output logic tick,
    output logic bclk_lvl
);

    localparam int DC_W = $clog2(2 * HALF_HI);

    logic [DC_W-1:0] dc_q;
    logic [DC_W-1:0] half;
    logic [DC_W-1:0] last;

    assign half     = hi_sel ? DC_W'(HALF_HI) : DC_W'(HALF_LO);
    assign last     = hi_sel ? DC_W'(2 * HALF_HI - 1) : DC_W'(2 * HALF_LO - 1);
    assign tick     = run && (dc_q == last);
    assign bclk_lvl = (dc_q >= half);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mclk_q <= 1'b0;
        end else begin
            mclk_q <= ~mclk_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dc_q <= '0;
        end else if (!run || restart || tick) begin
            dc_q <= '0;
        end else begin
            dc_q <= dc_q + 1'b1;
        end
    end

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dc_q <= last);  // R2

    AST_MCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mclk_q != $past(mclk_q)));  // R2

endmodule

// File: rtl/sao_framer.sv
module sao_framer
    import sao_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  fmt_cfg_t            cfg_in,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                tick,
    input  logic                bclk_lvl,
    output logic                smp_ready,
    output logic                run,
    output logic                restart,
    output logic                hi_sel,
    output logic                bclk_q,
    output logic                ws_q,
    output logic                sd_q,
    output logic                underrun_q
);

    frame_state_e        state_q, state_nxt;
    logic [SLOT_W-1:0]   slot_q;
    fmt_cfg_t            cfg_q;
    logic [SAMPLE_W-1:0] left_q, right_q;
    logic                half_end, frame_end, load;
    logic                bit_nxt;

    assign half_end  = tick && (slot_q == SLOT_W'(CH_SLOTS - 1));
    assign frame_end = tick && (slot_q == SLOT_W'(FRAME_SLOTS - 1));
    assign load      = (state_q == ST_IDLE) || frame_end;

    assign smp_ready = load;
    assign run       = (state_q != ST_IDLE);
    assign restart   = load;
    assign hi_sel    = cfg_q.mclk384;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:  state_nxt = ST_LEFT;
            ST_LEFT:  if (half_end)  state_nxt = ST_RIGHT;
            ST_RIGHT: if (frame_end) state_nxt = ST_LEFT;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // slot counter, configuration and sample capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q     <= '0;
            cfg_q      <= '0;
            left_q     <= '0;
            right_q    <= '0;
            underrun_q <= 1'b0;
        end else if (load) begin
            slot_q     <= '0;
            cfg_q      <= cfg_in;
            left_q     <= smp_valid ? smp_left  : '0;
            right_q    <= smp_valid ? smp_right : '0;
            underrun_q <= ~smp_valid;
        end else if (tick) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // bit selection for the current slot
    always_comb begin
        int w;
        int rel;
        int first;
        logic [IDX_W-1:0] idx;
        w       = word_bits(cfg_q.wcode);
        rel     = int'(slot_q[SLOT_W-2:0]);
        first   = cfg_q.rjust ? (CH_SLOTS - w) : 1;
        idx     = IDX_W'(SAMPLE_W - 1 - (rel - first));
        bit_nxt = 1'b0;
        if ((rel >= first) && (rel < first + w)) begin
            bit_nxt = (state_q == ST_RIGHT) ? right_q[idx] : left_q[idx];
        end
    end

    // registered line drivers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            ws_q   <= 1'b0;
            sd_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    bclk_q <= 1'b0;
                    ws_q   <= 1'b0;
                    sd_q   <= 1'b0;
                end
                ST_LEFT: begin
                    bclk_q <= bclk_lvl;
                    ws_q   <= 1'b0;
                    sd_q   <= bit_nxt;
                end
                ST_RIGHT: begin
                    bclk_q <= bclk_lvl;
                    ws_q   <= 1'b1;
                    sd_q   <= bit_nxt;
                end
                default: begin
                    bclk_q <= 1'b0;
                    ws_q   <= 1'b0;
                    sd_q   <= 1'b0;
                end
            endcase
        end
    end

    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws_q) |-> $fell(bclk_q));  // R11

    AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_q) |-> $fell(bclk_q));  // R11

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_ready && smp_valid) |=> !smp_ready);  // R7

    AST_UNDERRUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_q && $past(underrun_q)) |-> !sd_q);  // R8

    AST_WS_MATCHES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && state_q == ST_RIGHT) |=> ws_q);  // R3

endmodule

// File: rtl/sao_padgate.sv
module sao_padgate #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] lvl,
    input  logic [LANES-1:0] en,
    output logic [LANES-1:0] pad
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign pad[i] = lvl[i] & en[i];
    end

endmodule

// File: rtl/sao_serial_tx.sv
module sao_serial_tx
    import sao_pkg::*;
#(
    parameter int HALF_LO = 4,
    parameter int HALF_HI = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_width,
    input  logic                cfg_rjust,
    input  logic                cfg_mclk384,
    input  logic                en_data,
    input  logic                en_ws,
    input  logic                en_clk,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                mclk_o,
    output logic                bclk_o,
    output logic                ws_o,
    output logic                sd_o,
    output logic                oe_data,
    output logic                oe_ws,
    output logic                oe_clk,
    output logic                underrun
);

    localparam int LANES = 4;

    fmt_cfg_t   cfg_in;
    logic       run, restart, hi_sel, tick, bclk_lvl;
    logic       mclk_q, bclk_q, ws_q, sd_q;
    logic [LANES-1:0] pad_lvl, pad_en, pad_out;

    assign cfg_in = '{wcode: cfg_width, rjust: cfg_rjust, mclk384: cfg_mclk384};

    sao_clkdiv #(
        .HALF_LO (HALF_LO),
        .HALF_HI (HALF_HI)
    ) i_clkdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .restart  (restart),
        .hi_sel   (hi_sel),
        .mclk_q   (mclk_q),
        .tick     (tick),
        .bclk_lvl (bclk_lvl)
    );

    sao_framer i_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_in     (cfg_in),
        .smp_valid  (smp_valid),
        .smp_left   (smp_left),
        .smp_right  (smp_right),
        .tick       (tick),
        .bclk_lvl   (bclk_lvl),
        .smp_ready  (smp_ready),
        .run        (run),
        .restart    (restart),
        .hi_sel     (hi_sel),
        .bclk_q     (bclk_q),
        .ws_q       (ws_q),
        .sd_q       (sd_q),
        .underrun_q (underrun)
    );

    assign pad_lvl = {mclk_q, bclk_q, ws_q, sd_q};
    assign pad_en  = {en_clk, en_clk, en_ws, en_data};

    sao_padgate #(.LANES(LANES)) i_padgate (
        .lvl (pad_lvl),
        .en  (pad_en),
        .pad (pad_out)
    );

    assign {mclk_o, bclk_o, ws_o, sd_o} = pad_out;
    assign oe_data = en_data;
    assign oe_ws   = en_ws;
    assign oe_clk  = en_clk;

endmodule

// File: tb/test_sao_serial_tx.sv
module test_sao_serial_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'd0;
    logic        cfg_rjust = 1'b0;
    logic        cfg_mclk384 = 1'b0;
    logic        en_data = 1'b1, en_ws = 1'b1, en_clk = 1'b1;
    logic        smp_valid = 1'b0;
    logic        smp_ready;
    logic [21:0] smp_left = '0, smp_right = '0;
    logic        mclk_o, bclk_o, ws_o, sd_o, oe_data, oe_ws, oe_clk, underrun;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit feed = 1'b1;
    bit done = 1'b0;

    // reference model state
    bit          m_run = 0, m_rj = 0, m_hi = 0, m_und = 0, m_mclk = 0;
    int          m_dc = 0, m_slot = 0, m_w = 16, seq = 0;
    logic [21:0] m_l = '0, m_r = '0;
    bit          e_b = 0, e_ws = 0, e_sd = 0, acc = 0;
    bit          p_b = 0, p_ws = 0, p_sd = 0, p_allen = 0;

    always #5 clk = ~clk;

    sao_serial_tx i_sao_serial_tx (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_rjust(cfg_rjust),
        .cfg_mclk384(cfg_mclk384), .en_data(en_data), .en_ws(en_ws), .en_clk(en_clk),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_left(smp_left),
        .smp_right(smp_right), .mclk_o(mclk_o), .bclk_o(bclk_o), .ws_o(ws_o),
        .sd_o(sd_o), .oe_data(oe_data), .oe_ws(oe_ws), .oe_clk(oe_clk),
        .underrun(underrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    function automatic int half_of(input bit hi);
        return hi ? 6 : 4;
    endfunction

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        int h, rel, first;
        logic [21:0] cur;
        bit load;
        cyc++;
        if (!rst_n) begin
            m_run = 0; m_dc = 0; m_slot = 0; m_w = 16; m_rj = 0; m_hi = 0;
            m_l = '0; m_r = '0; m_und = 0; m_mclk = 0;
            e_b = 0; e_ws = 0; e_sd = 0; acc = 0;
        end else begin
            h = half_of(m_hi);
            if (!m_run) begin
                e_b = 0; e_ws = 0; e_sd = 0;
            end else begin
                e_b   = (m_dc >= h);
                e_ws  = (m_slot >= 32);
                rel   = m_slot % 32;
                first = m_rj ? 32 - m_w : 1;
                cur   = (m_slot >= 32) ? m_r : m_l;
                e_sd  = 0;
                if (rel >= first && rel < first + m_w) e_sd = cur[21 - (rel - first)];
            end
            m_mclk = !m_mclk;
            load = !m_run || (m_dc == 2*h - 1 && m_slot == 63);
            acc  = load && smp_valid;
            if (load) begin
                m_w   = 16 + 2 * int'(cfg_width);
                m_rj  = cfg_rjust;
                m_hi  = cfg_mclk384;
                m_l   = smp_valid ? smp_left : '0;
                m_r   = smp_valid ? smp_right : '0;
                m_und = !smp_valid;
                m_dc  = 0; m_slot = 0; m_run = 1;
            end else if (m_dc == 2*h - 1) begin
                m_dc = 0; m_slot = m_slot + 1;
            end else begin
                m_dc = m_dc + 1;
            end
        end
    end

    // sample source
    always @(negedge clk) begin
        smp_valid <= feed;
        if (acc) begin
            seq++;
            smp_left  <= 22'(seq * 32'h2B5A3 + 32'h1357);
            smp_right <= 22'(~(seq * 32'h1C3D5) ^ (seq << 3));
        end
    end

    // comparison away from the edge
    always @(negedge clk) begin
        int h;
        bit pend, allen;
        string sd_tag;
        #2;
        if (rst_n && cyc > 2 && !done) begin
            h    = half_of(m_hi);
            pend = (16 + 2 * int'(cfg_width) != m_w) || (cfg_rjust != m_rj) || (cfg_mclk384 != m_hi);
            sd_tag = pend ? "R9" : (m_rj ? "R5" : (m_w != 16 ? "R6" : "R4"));
            chk("R2 mclk", mclk_o, m_mclk & en_clk);
            chk(pend ? "R9 bclk" : "R2 bclk", bclk_o, e_b & en_clk);
            chk("R3 ws", ws_o, e_ws & en_ws);
            chk(sd_tag, sd_o, e_sd & en_data);
            chk("R7 ready", smp_ready, (!m_run || (m_dc == 2*h - 1 && m_slot == 63)) ? 1 : 0);
            chk("R8 underrun", underrun, m_und);
            chk("R10 oe", {oe_clk, oe_ws, oe_data}, {en_clk, en_ws, en_data});
            allen = en_data && en_ws && en_clk;
            if (allen && p_allen && ((sd_o != p_sd) || (ws_o != p_ws))) begin
                chk("R11 edge", bclk_o, 0);
                chk("R11 edge", p_b, 1);
            end
            p_b = bclk_o; p_ws = ws_o; p_sd = sd_o; p_allen = allen;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #3;
        // R1: reset state
        chk("R1 sd", sd_o, 0);
        chk("R1 ws", ws_o, 0);
        chk("R1 bclk", bclk_o, 0);
        chk("R1 mclk", mclk_o, 0);
        chk("R1 underrun", underrun, 0);
        chk("R1 ready", smp_ready, 1);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 standard framing, 16 bits, 256x
        repeat (3 * 512) @(negedge clk);

        // R9 change mid-frame to right-justified, 22 bits, 384x (R5, R6)
        repeat (200) @(negedge clk);
        cfg_width = 2'd3; cfg_rjust = 1'b1; cfg_mclk384 = 1'b1;
        repeat (4 * 768) @(negedge clk);

        // R6 18 bits standard at 384x
        cfg_width = 2'd1; cfg_rjust = 1'b0;
        repeat (3 * 768) @(negedge clk);

        // R6 20 bits right-justified at 256x
        cfg_width = 2'd2; cfg_rjust = 1'b1; cfg_mclk384 = 1'b0;
        repeat (3 * 512) @(negedge clk);

        // R8 starve the source
        feed = 1'b0;
        repeat (2 * 512) @(negedge clk);
        feed = 1'b1;
        repeat (600) @(negedge clk);

        // R10 pad disables
        en_data = 1'b0;
        repeat (300) @(negedge clk);
        en_ws = 1'b0; en_clk = 1'b0;
        repeat (300) @(negedge clk);
        #3;
        chk("R10 pads off", {mclk_o, bclk_o, ws_o, sd_o}, 0);
        chk("R10 oe off", {oe_clk, oe_ws, oe_data}, 0);
        en_data = 1'b1; en_ws = 1'b1; en_clk = 1'b1;
        repeat (700) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule